// File: doc/BRIEF.md
# Two-Channel Serial Port Status and Interrupt Logic

This block is the register-side front of a two-channel asynchronous serial port. It sits between a CPU register bus and the transmit and receive shifters. Each channel has a transmit holding register at a fixed I/O address and a "holding register empty" flag. The CPU reads the flag before it writes the next byte, and the transmit shifter marks the byte as taken. Transmit interrupt enables turn the empty flags into level interrupt requests.

Channel 0 also handles modem control. A synchronized clear-to-send input can hold its empty flag low when automatic handshake is on. The data-carrier-detect input drives a latched status bit, a receive interrupt and a receiver hold-in-reset signal. On channel 1, one input pin is shared: a control bit routes it either to a clear-to-send output or to a clocked-serial receive-data output.

Both modem inputs pass through a synchronizer before the flag logic uses them. Shifters, baud generation and framing are outside this block. The transmit shifter appears only as a one-cycle "take" pulse per channel.

Top module: `ssi_stat_irq`

## Requirements
- R1: While reset is asserted, and straight after it, both empty flags read 1. The transmit and receive interrupt enables, the channel 1 routing bit and both option bits are 0. The carrier status bit, both transmit interrupts and the receive interrupt are 0.
- R2: A bus write to address 06h loads the channel 0 holding register, and a write to 07h loads the channel 1 holding register. The new byte appears on that channel's data output, and the channel's empty flag reads 0 from the next cycle.
- R3: A take pulse from the shifter sets that channel's empty flag back to 1. If a write and a take for the same channel fall in the same cycle, the write wins and the flag reads 0.
- R4: While the I/O-stop input is high, both empty flags read 1 and the stored flags are forced to 1. A write during stop still loads the data byte but leaves the flag at 1 after stop ends.
- R5: When the option register (address 12h) bit 5 is 1 and the synchronized channel-0 clear-to-send pin is high, channel 0's empty flag reads 0. It reads its stored value again once the pin is low. Channel 1 is never gated this way.
- R6: The carrier status bit (status 0 at address 04h, bit 2) reads 1 while the synchronized carrier pin is high. After the pin falls, the bit stays 1 until the first bus read of address 04h. That read returns 1, and the bit is 0 from the next cycle. A read while the pin is still high does not clear it.
- R7: The receiver reset output is high exactly when option bit 6 is 0 and the synchronized carrier pin is high.
- R8: The receive interrupt is high exactly when the receive interrupt enable (address 04h, bit 3) is 1 and the carrier status bit is 1.
- R9: Each transmit interrupt is high exactly when its enable (bit 0 of 04h for channel 0, bit 0 of 05h for channel 1) is 1 and its channel's empty flag reads 1.
- R10: With address 05h bit 2 set to 1, the shared channel 1 pin drives the clear-to-send output and the serial receive-data output idles at 1. With the bit at 0, the pin drives the receive-data output and the clear-to-send output idles at 1.
- R11: A change on the carrier or channel-0 clear-to-send pin takes effect after two rising clock edges.
- R12: The read-data output is combinational on the address. Address 04h returns {0000, rie, carrier, empty0, tie0}. Address 05h returns {00000, route, empty1, tie1}. Address 12h returns {0, bit6, bit5, 00000}. Addresses 06h and 07h return the held bytes. Every other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| rd_data | output | DATA_W | Read data for bus_addr |
| iostop | input | 1 | I/O-stop mode |
| tx_take | input | 2 | Shifter took the byte, per channel |
| cts0_pin | input | 1 | Channel 0 clear-to-send pin (high = negated) |
| dcd0_pin | input | 1 | Channel 0 carrier pin (high = negated) |
| ch1_shared_pin | input | 1 | Channel 1 shared pin |
| tx_data0 | output | DATA_W | Channel 0 holding register |
| tx_data1 | output | DATA_W | Channel 1 holding register |
| tdre | output | 2 | Empty flags, as read |
| tx_irq | output | 2 | Transmit interrupt requests |
| rx_irq | output | 1 | Channel 0 receive interrupt request |
| rx_reset0 | output | 1 | Channel 0 receiver held in reset |
| dcd0_stat | output | 1 | Carrier status bit |
| cts1_out | output | 1 | Channel 1 clear-to-send function |
| csio_rxd | output | 1 | Clocked-serial receive data |

## Verification
Two events can land in the same cycle and change the same flag. A CPU write to a holding register can coincide with a take pulse from the shifter. A status read can coincide with the carrier pin's state (still high, or just fallen). The bench forces both cases on purpose: write and take together, a read during a high carrier, and a read after a fall. A long pseudo-random phase then mixes all inputs further. A behavioural model, updated on each rising edge, predicts every output, and the bench compares the two on every falling edge. The model resolves each collision by the priority written in R3 and R6.

// File: rtl/ssi_pkg.sv
package ssi_pkg;
   localparam int NCH         = 2;
   // status 0 / status 1 bit positions
   localparam int B_TIE       = 0;
   localparam int B_TDRE      = 1;
   localparam int B_DCD       = 2;
   localparam int B_RIE       = 3;
   localparam int B_ROUTE1    = 2;
   // option register bit positions
   localparam int B_CTS_AUTO  = 5;
   localparam int B_DCD_DIS   = 6;

   typedef struct packed {
      logic rie0;
      logic route1;
      logic cts_auto;
      logic dcd_dis;
   } ssi_ctl_t;
endpackage

// File: rtl/ssi_sync.sv
module ssi_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) stg[i] <= '0;
               else        stg[i] <= d;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) stg[i] <= '0;
               else        stg[i] <= stg[i-1];
         end
      end
   endgenerate

   assign q = stg[STAGES-1];
endmodule

// File: rtl/ssi_txchan.sv
module ssi_txchan #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              iostop,
   input  logic              ld,
   input  logic              ctl_wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              take,
   input  logic              blk,
   output logic [DATA_W-1:0] data_o,
   output logic              tdre_o,
   output logic              tie_o,
   output logic              irq_o
);
   import ssi_pkg::*;

   logic empty_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         empty_q <= 1'b1;
         data_o  <= '0;
         tie_o   <= 1'b0;
      end else begin
         if (iostop)    empty_q <= 1'b1;
         else if (ld)   empty_q <= 1'b0;
         else if (take) empty_q <= 1'b1;
         if (ld)     data_o <= wdata;
         if (ctl_wr) tie_o  <= wdata[B_TIE];
      end
   end

   assign tdre_o = iostop | (empty_q & ~blk);
   assign irq_o  = tie_o & tdre_o;
endmodule

// File: rtl/ssi_dcd.sv
module ssi_dcd (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_s,
   input  logic stat_rd,
   input  logic dis,
   output logic status_o,
   output logic rx_reset_o
);
   logic hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       hold_q <= 1'b0;
      else if (pin_s)   hold_q <= 1'b1;
      else if (stat_rd) hold_q <= 1'b0;
   end

   assign status_o   = pin_s | hold_q;
   assign rx_reset_o = ~dis & pin_s;
endmodule

// File: rtl/ssi_stat_irq.sv
module ssi_stat_irq #(
   parameter int              DATA_W      = 8,
   parameter int              ADDR_W      = 8,
   parameter int              SYNC_STAGES = 2,
   parameter logic [ADDR_W-1:0] STAT0_ADDR = 'h04,
   parameter logic [ADDR_W-1:0] STAT1_ADDR = 'h05,
   parameter logic [ADDR_W-1:0] TXD0_ADDR  = 'h06,
   parameter logic [ADDR_W-1:0] TXD1_ADDR  = 'h07,
   parameter logic [ADDR_W-1:0] OPT_ADDR   = 'h12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_wr,
   input  logic              bus_rd,
   output logic [DATA_W-1:0] rd_data,
   input  logic              iostop,
   input  logic [1:0]        tx_take,
   input  logic              cts0_pin,
   input  logic              dcd0_pin,
   input  logic              ch1_shared_pin,
   output logic [DATA_W-1:0] tx_data0,
   output logic [DATA_W-1:0] tx_data1,
   output logic [1:0]        tdre,
   output logic [1:0]        tx_irq,
   output logic              rx_irq,
   output logic              rx_reset0,
   output logic              dcd0_stat,
   output logic              cts1_out,
   output logic              csio_rxd
);
   import ssi_pkg::*;

   localparam int NSYNC = 2;

   generate
      if (DATA_W < 8) begin : g_bad_w
         $error("ssi_stat_irq: DATA_W must be at least 8");
      end
      if (SYNC_STAGES < 2) begin : g_bad_s
         $error("ssi_stat_irq: SYNC_STAGES must be at least 2");
      end
   endgenerate

   ssi_ctl_t          ctl_q;
   logic [NSYNC-1:0]  pins_s;
   logic [NCH-1:0]    tie;
   logic [DATA_W-1:0] chdata [NCH];
   logic              wr_st0, wr_st1, wr_opt, rd_st0;

   assign wr_st0 = bus_wr && (bus_addr == STAT0_ADDR);
   assign wr_st1 = bus_wr && (bus_addr == STAT1_ADDR);
   assign wr_opt = bus_wr && (bus_addr == OPT_ADDR);
   assign rd_st0 = bus_rd && (bus_addr == STAT0_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
      end else begin
         if (wr_st0) ctl_q.rie0   <= bus_wdata[B_RIE];
         if (wr_st1) ctl_q.route1 <= bus_wdata[B_ROUTE1];
         if (wr_opt) begin
            ctl_q.cts_auto <= bus_wdata[B_CTS_AUTO];
            ctl_q.dcd_dis  <= bus_wdata[B_DCD_DIS];
         end
      end
   end

   ssi_sync #(.W(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({cts0_pin, dcd0_pin}),
      .q     (pins_s)
   );

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         logic blk_c;
         logic ld_c;
         logic ctl_c;
         if (c == 0) begin : g_gated
            assign blk_c = ctl_q.cts_auto & pins_s[1];
            assign ld_c  = bus_wr && (bus_addr == TXD0_ADDR);
            assign ctl_c = wr_st0;
         end else begin : g_free
            assign blk_c = 1'b0;
            assign ld_c  = bus_wr && (bus_addr == TXD1_ADDR);
            assign ctl_c = wr_st1;
         end
         ssi_txchan #(.DATA_W(DATA_W)) u_tx (
            .clk    (clk),
            .rst_n  (rst_n),
            .iostop (iostop),
            .ld     (ld_c),
            .ctl_wr (ctl_c),
            .wdata  (bus_wdata),
            .take   (tx_take[c]),
            .blk    (blk_c),
            .data_o (chdata[c]),
            .tdre_o (tdre[c]),
            .tie_o  (tie[c]),
            .irq_o  (tx_irq[c])
         );
      end
   endgenerate

   assign tx_data0 = chdata[0];
   assign tx_data1 = chdata[1];

   ssi_dcd u_dcd (
      .clk        (clk),
      .rst_n      (rst_n),
      .pin_s      (pins_s[0]),
      .stat_rd    (rd_st0),
      .dis        (ctl_q.dcd_dis),
      .status_o   (dcd0_stat),
      .rx_reset_o (rx_reset0)
   );

   assign rx_irq   = ctl_q.rie0 & dcd0_stat;
   assign cts1_out = ctl_q.route1 ? ch1_shared_pin : 1'b1;
   assign csio_rxd = ctl_q.route1 ? 1'b1 : ch1_shared_pin;

   always_comb begin
      rd_data = '0;
      if (bus_addr == STAT0_ADDR) begin
         rd_data[B_TIE]  = tie[0];
         rd_data[B_TDRE] = tdre[0];
         rd_data[B_DCD]  = dcd0_stat;
         rd_data[B_RIE]  = ctl_q.rie0;
      end else if (bus_addr == STAT1_ADDR) begin
         rd_data[B_TIE]    = tie[1];
         rd_data[B_TDRE]   = tdre[1];
         rd_data[B_ROUTE1] = ctl_q.route1;
      end else if (bus_addr == OPT_ADDR) begin
         rd_data[B_CTS_AUTO] = ctl_q.cts_auto;
         rd_data[B_DCD_DIS]  = ctl_q.dcd_dis;
      end else if (bus_addr == TXD0_ADDR) begin
         rd_data = chdata[0];
      end else if (bus_addr == TXD1_ADDR) begin
         rd_data = chdata[1];
      end
   end
endmodule

// File: rtl/ssi_stat_irq_chk.sv
module ssi_stat_irq_chk #(
   parameter int                ADDR_W     = 8,
   parameter logic [ADDR_W-1:0] STAT0_ADDR = 'h04,
   parameter logic [ADDR_W-1:0] TXD0_ADDR  = 'h06
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic              iostop,
   input logic [1:0]        tdre,
   input logic [1:0]        tx_irq,
   input logic              rx_irq,
   input logic              rx_reset0,
   input logic              dcd0_stat,
   input logic              cts1_out,
   input logic              csio_rxd
);
   AST_WR_CLEARS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == TXD0_ADDR && !iostop) |=> (!tdre[0] || iostop)); // R2
   AST_STOP_FORCES_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      iostop |-> (tdre == 2'b11)); // R4
   AST_DCD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (dcd0_stat && !(bus_rd && bus_addr == STAT0_ADDR)) |=> dcd0_stat); // R6
   AST_RXRST_NEEDS_DCD: assert property (@(posedge clk) disable iff (!rst_n)
      rx_reset0 |-> dcd0_stat); // R7
   AST_RXIRQ_NEEDS_DCD: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq |-> dcd0_stat); // R8
   AST_TXIRQ0_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      tx_irq[0] |-> tdre[0]); // R9
   AST_TXIRQ1_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      tx_irq[1] |-> tdre[1]); // R9
   AST_ONE_ROUTE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (cts1_out || csio_rxd)); // R10
endmodule

bind ssi_stat_irq ssi_stat_irq_chk #(
   .ADDR_W(ADDR_W), .STAT0_ADDR(STAT0_ADDR), .TXD0_ADDR(TXD0_ADDR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
   .bus_rd(bus_rd), .iostop(iostop), .tdre(tdre), .tx_irq(tx_irq),
   .rx_irq(rx_irq), .rx_reset0(rx_reset0), .dcd0_stat(dcd0_stat),
   .cts1_out(cts1_out), .csio_rxd(csio_rxd)
);

// File: tb/ssi_stat_irq_tb.sv
`timescale 1ns/1ps
module ssi_stat_irq_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] bus_addr = '0, bus_wdata = '0, rd_data;
   logic       bus_wr = 1'b0, bus_rd = 1'b0, iostop = 1'b0;
   logic [1:0] tx_take = '0;
   logic       cts0_pin = 1'b0, dcd0_pin = 1'b0, ch1_shared_pin = 1'b0;
   logic [7:0] tx_data0, tx_data1;
   logic [1:0] tdre, tx_irq;
   logic       rx_irq, rx_reset0, dcd0_stat, cts1_out, csio_rxd;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   ssi_stat_irq u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .rd_data(rd_data), .iostop(iostop),
      .tx_take(tx_take), .cts0_pin(cts0_pin), .dcd0_pin(dcd0_pin),
      .ch1_shared_pin(ch1_shared_pin), .tx_data0(tx_data0), .tx_data1(tx_data1),
      .tdre(tdre), .tx_irq(tx_irq), .rx_irq(rx_irq), .rx_reset0(rx_reset0),
      .dcd0_stat(dcd0_stat), .cts1_out(cts1_out), .csio_rxd(csio_rxd)
   );

   // behavioural reference model
   bit       m_emp [2];
   bit [7:0] m_dat [2];
   bit       m_tie [2];
   bit       m_rie, m_route, m_auto, m_dis;
   bit       d_a, d_b, c_a, c_b, m_latched;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int c = 0; c < 2; c++) begin
            m_emp[c] <= 1'b1; m_dat[c] <= '0; m_tie[c] <= 1'b0;
         end
         m_rie <= 0; m_route <= 0; m_auto <= 0; m_dis <= 0;
         d_a <= 0; d_b <= 0; c_a <= 0; c_b <= 0; m_latched <= 0;
      end else begin
         d_a <= dcd0_pin; d_b <= d_a; c_a <= cts0_pin; c_b <= c_a;
         if (d_b) m_latched <= 1'b1;
         else if (bus_rd && bus_addr == 8'h04) m_latched <= 1'b0;
         for (int c = 0; c < 2; c++) begin
            if (bus_wr && bus_addr == 8'h06 + c) m_dat[c] <= bus_wdata;
            if (iostop) m_emp[c] <= 1'b1;
            else if (bus_wr && bus_addr == 8'h06 + c) m_emp[c] <= 1'b0;
            else if (tx_take[c]) m_emp[c] <= 1'b1;
         end
         if (bus_wr && bus_addr == 8'h04) begin
            m_tie[0] <= bus_wdata[0]; m_rie <= bus_wdata[3];
         end
         if (bus_wr && bus_addr == 8'h05) begin
            m_tie[1] <= bus_wdata[0]; m_route <= bus_wdata[2];
         end
         if (bus_wr && bus_addr == 8'h12) begin
            m_auto <= bus_wdata[5]; m_dis <= bus_wdata[6];
         end
      end
   end

   function automatic bit m_tdre(int c);
      return iostop || (m_emp[c] && !(c == 0 && m_auto && c_b));
   endfunction

   function automatic bit m_dcd();
      return d_b || m_latched;
   endfunction

   function automatic bit [7:0] m_rd(bit [7:0] a);
      case (a)
         8'h04: return {4'b0, m_rie, m_dcd(), m_tdre(0), m_tie[0]};
         8'h05: return {5'b0, m_route, m_tdre(1), m_tie[1]};
         8'h12: return {1'b0, m_dis, m_auto, 5'b0};
         8'h06: return m_dat[0];
         8'h07: return m_dat[1];
         default: return 8'h00;
      endcase
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
      end
   endtask

   // per-cycle comparison against the model, away from the rising edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R2/R3/R4/R5 tdre", tdre, {m_tdre(1), m_tdre(0)});
         chk("R2 tx_data0", tx_data0, m_dat[0]);
         chk("R2 tx_data1", tx_data1, m_dat[1]);
         chk("R9 tx_irq", tx_irq, {m_tie[1] & m_tdre(1), m_tie[0] & m_tdre(0)});
         chk("R6/R11 dcd0_stat", dcd0_stat, m_dcd());
         chk("R7 rx_reset0", rx_reset0, !m_dis && d_b);
         chk("R8 rx_irq", rx_irq, m_rie && m_dcd());
         chk("R10 routing", {cts1_out, csio_rxd},
             {m_route ? ch1_shared_pin : 1'b1, m_route ? 1'b1 : ch1_shared_pin});
         chk("R12 rd_data", rd_data, m_rd(bus_addr));
      end
   end

   task automatic cyc(int n = 1);
      repeat (n) begin
         @(posedge clk);
         #2;
      end
   endtask

   task automatic wr(bit [7:0] a, bit [7:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      cyc();
      bus_wr = 1'b0;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      int unsigned lfsr = 32'hACE1_2357;
      cyc(3);
      // R1 reset state
      chk("R1 tdre", tdre, 2'b11);
      chk("R1 irqs", {tx_irq, rx_irq, dcd0_stat}, 4'b0);
      rst_n = 1'b1;
      cyc();
      chk("R1 after release", {tdre, tx_irq, rx_irq, dcd0_stat}, 6'b110000);
      // R2 writes
      wr(8'h06, 8'hA5);
      chk("R2 tdre0 cleared", tdre[0], 1'b0);
      chk("R2 data0", tx_data0, 8'hA5);
      wr(8'h07, 8'h3C);
      chk("R2 tdre1 cleared", tdre[1], 1'b0);
      wr(8'h04, 8'h01);
      wr(8'h05, 8'h01);
      chk("R9 no irq while full", tx_irq, 2'b00);
      // R3 take
      tx_take = 2'b01; cyc(); tx_take = 2'b00;
      chk("R3 take sets empty", tdre[0], 1'b1);
      chk("R9 irq0 raised", tx_irq[0], 1'b1);
      tx_take = 2'b10; bus_addr = 8'h07; bus_wdata = 8'h77; bus_wr = 1'b1;
      cyc(); bus_wr = 1'b0; tx_take = 2'b00;
      chk("R3 write beats take", tdre[1], 1'b0);
      // R4 stop
      iostop = 1'b1; wr(8'h06, 8'h11);
      chk("R4 stop forces empty", tdre, 2'b11);
      chk("R4 data loaded", tx_data0, 8'h11);
      iostop = 1'b0; cyc();
      chk("R4 flag kept after stop", tdre, 2'b11);
      // R5 / R11 clear-to-send gate
      wr(8'h12, 8'h20);
      cts0_pin = 1'b1; cyc();
      chk("R11 one edge not enough", tdre[0], 1'b1);
      cyc();
      chk("R5 cts gates tdre0", tdre, 2'b10);
      cts0_pin = 1'b0; cyc(2);
      chk("R5 gate released", tdre[0], 1'b1);
      // R6-R8 carrier
      wr(8'h04, 8'h09);
      dcd0_pin = 1'b1; cyc(2);
      chk("R6 dcd high", dcd0_stat, 1'b1);
      chk("R7 rx reset", rx_reset0, 1'b1);
      chk("R8 rx irq", rx_irq, 1'b1);
      bus_addr = 8'h04; bus_rd = 1'b1; cyc(); bus_rd = 1'b0;
      chk("R6 read while high keeps bit", dcd0_stat, 1'b1);
      wr(8'h12, 8'h40);
      chk("R7 disabled", rx_reset0, 1'b0);
      dcd0_pin = 1'b0; cyc(4);
      chk("R6 latched after fall", dcd0_stat, 1'b1);
      bus_addr = 8'h04; bus_rd = 1'b1; #1;
      chk("R6 read returns 1", rd_data[2], 1'b1);
      cyc(); bus_rd = 1'b0;
      chk("R6 cleared by read", dcd0_stat, 1'b0);
      chk("R8 rx irq drops", rx_irq, 1'b0);
      // R10 routing
      ch1_shared_pin = 1'b0; #1;
      chk("R10 to serial rx", {cts1_out, csio_rxd}, 2'b10);
      wr(8'h05, 8'h04);
      chk("R10 to cts", {cts1_out, csio_rxd}, 2'b01);
      // R12 read-back across addresses
      for (int i = 0; i < 8; i++) begin
         bus_addr = 8'h03 + i[7:0]; cyc();
      end
      // mixed pseudo-random phase, judged by the model
      for (int i = 0; i < 3000; i++) begin
         lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
         case (lfsr[2:0])
            3'd0: bus_addr = 8'h04; 3'd1: bus_addr = 8'h05;
            3'd2: bus_addr = 8'h06; 3'd3: bus_addr = 8'h07;
            3'd4: bus_addr = 8'h12; default: bus_addr = 8'h00;
         endcase
         bus_wdata      = lfsr[15:8];
         bus_wr         = (lfsr[18:16] == 3'd0);
         bus_rd         = lfsr[19];
         tx_take        = lfsr[21:20] & {lfsr[22], lfsr[22]};
         iostop         = (lfsr[26:23] == 4'd0);
         if (lfsr[29:27] == 3'd0) dcd0_pin = ~dcd0_pin;
         if (lfsr[31:30] == 2'd0) cts0_pin = ~cts0_pin;
         ch1_shared_pin = lfsr[12];
         cyc();
      end
      bus_wr = 1'b0; bus_rd = 1'b0; tx_take = 2'b00; iostop = 1'b0;
      cyc(2);
      finish_run();
   end
endmodule